// File: doc/BRIEF.md
# Alarm and Interrupt Flag Unit

This block sits beside a real-time clock's calendar counter and divider chain. It holds three alarm bytes (seconds, minutes, hours) and compares them with the current time once per calendar update, after the new time has been written. It also gathers three event sources into a flag register: update-ended, alarm match and periodic tick. Each source has an enable bit. A summary bit and an active-high interrupt line are raised only when at least one enabled flag is set.

Software reaches the block through a byte-wide register port with a one-cycle read latency. Reading the flag register returns the pending flags and clears them. Events that arrive during that clearing read are kept. A status register always reports valid RAM and time. The time values and the event pulses come from outside the block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The alarm bytes for seconds, minutes and hours are at offsets 1, 3 and 5. Each one is written by `reg_wr` and reads back what was written. All three are 0 after reset.
- R2: The alarm flag is bit 5 of the flag register at offset 12. It is set one clock after an `upd_done` pulse during which all three current time bytes match their alarm bytes. A match without `upd_done` sets nothing.
- R3: An alarm byte whose bits 7 and 6 are both 1 matches any current value. An alarm byte with only bit 7 set is compared exactly.
- R4: The update-ended flag is bit 4 and is set by every `upd_done` pulse. The periodic flag is bit 6 and is set by every `per_tick` pulse. Both are set whether or not their enables are on.
- R5: The enable register is at offset 11. Bit 4 enables update-ended, bit 5 enables alarm and bit 6 enables periodic. Its other bits read as 0, and it is 0 after reset.
- R6: Bit 7 of the flag register and the `irq` output are 1 exactly when some flag is set together with its enable. Without enables, `irq` stays 0.
- R7: A read of offset 12 returns {summary, periodic, alarm, update-ended, 4'b0000} and clears all flags at the same clock edge. The read data appears one clock after `reg_rd`.
- R8: An event that arrives in the same clock as a clearing read of offset 12 is not in that read's data. It is kept for the next read.
- R9: Offset 13 always reads 0x80, the valid-RAM-and-time bit. Writes to it have no effect.
- R10: Writes to offset 12 and to any offset outside the map are ignored. Reads of unmapped offsets, such as 14 and above, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one clock after reg_rd |
| cur_sec | input | 8 | Current seconds from the calendar |
| cur_min | input | 8 | Current minutes from the calendar |
| cur_hour | input | 8 | Current hours from the calendar |
| upd_done | input | 1 | One-clock pulse when a calendar update has finished |
| per_tick | input | 1 | One-clock periodic event pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit offset and the register offsets named above. With a 6-bit offset the general-purpose storage range above offset 13 can be addressed. This lets the bench show that reads and writes there are ignored and leave the alarm bytes untouched. With the default offsets, every scenario also drives the exact decode positions that neighbouring logic relies on. These scenarios cover the don't-care encodings, enable masking, and a read-clear that coincides with an incoming event.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_ALM    = 3;   // seconds, minutes, hours
  localparam int N_SRC    = 3;   // update-ended, alarm, periodic
  localparam int UF_BIT   = 4;   // lowest flag / enable position
  localparam int IRQF_BIT = 7;
  localparam int VRT_BIT  = 7;

  // one alarm byte against one time byte; top two bits set = wildcard
  function automatic logic alarm_field_hit(input logic [BYTE_W-1:0] alm,
                                           input logic [BYTE_W-1:0] cur);
    return (alm[BYTE_W-1 -: 2] == 2'b11) || (alm == cur);
  endfunction

  // flag register image: {summary, flags, zeros}
  function automatic logic [BYTE_W-1:0] pack_flags(input logic irqf,
                                                   input logic [N_SRC-1:0] f);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[IRQF_BIT] = irqf;
    v[UF_BIT +: N_SRC] = f;
    return v;
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
(
  input  logic [N_ALM-1:0][BYTE_W-1:0] alarm,
  input  logic [N_ALM-1:0][BYTE_W-1:0] cur,
  output logic                         hit
);
  logic [N_ALM-1:0] field_hit;

  for (genvar g = 0; g < N_ALM; g++) begin : g_field
    assign field_hit[g] = alarm_field_hit(alarm[g], cur[g]);
  end

  assign hit = &field_hit;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int OFS_ASEC  = 1,
  parameter int OFS_AMIN  = 3,
  parameter int OFS_AHOUR = 5,
  parameter int OFS_B     = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [N_ALM-1:0][BYTE_W-1:0] alarm,
  output logic [N_SRC-1:0]             en
);
  function automatic logic [ADDR_W-1:0] alm_ofs(input int i);
    case (i)
      0:       return ADDR_W'(OFS_ASEC);
      1:       return ADDR_W'(OFS_AMIN);
      default: return ADDR_W'(OFS_AHOUR);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm <= '0;
      en    <= '0;
    end else if (wr) begin
      for (int i = 0; i < N_ALM; i++)
        if (addr == alm_ofs(i)) alarm[i] <= wdata;
      if (addr == ADDR_W'(OFS_B)) en <= wdata[UF_BIT +: N_SRC];
    end
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,     // bit0 update-ended, bit1 alarm, bit2 periodic
  input  logic             rd_clr,
  input  logic [N_SRC-1:0] en,
  output logic [N_SRC-1:0] flags,
  output logic             irqf
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_clr ? '0 : flags) | evt;
  end

  assign irqf = |(flags & en);

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    // R4
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flags[g]);
    // R8
    flag_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[g]) |-> $past(evt[g]));
  end

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int OFS_ASEC  = 1,
  parameter int OFS_AMIN  = 3,
  parameter int OFS_AHOUR = 5,
  parameter int OFS_B     = 11,
  parameter int OFS_C     = 12,
  parameter int OFS_D     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic              upd_done,
  input  logic              per_tick,
  output logic              irq
);
  logic [N_ALM-1:0][BYTE_W-1:0] alarm;
  logic [N_ALM-1:0][BYTE_W-1:0] cur_time;
  logic [N_SRC-1:0]             en;
  logic [N_SRC-1:0]             evt_vec;
  logic [N_SRC-1:0]             flag_bits;
  logic                         alarm_hit;
  logic                         irq_sum;
  logic                         rd_clr;
  logic [BYTE_W-1:0]            rd_mux;

  assign cur_time = {cur_hour, cur_min, cur_sec};

  rtc_regs #(
    .ADDR_W(ADDR_W), .OFS_ASEC(OFS_ASEC), .OFS_AMIN(OFS_AMIN),
    .OFS_AHOUR(OFS_AHOUR), .OFS_B(OFS_B)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .alarm(alarm), .en(en)
  );

  rtc_alarm_cmp u_cmp (.alarm(alarm), .cur(cur_time), .hit(alarm_hit));

  // alarm is judged only at the update strobe, after the new time is in
  assign evt_vec = {per_tick, upd_done & alarm_hit, upd_done};
  assign rd_clr  = reg_rd && (reg_addr == ADDR_W'(OFS_C));

  rtc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .rd_clr(rd_clr),
    .en(en), .flags(flag_bits), .irqf(irq_sum)
  );

  assign irq = irq_sum;

  always_comb begin
    rd_mux = '0;
    if      (reg_addr == ADDR_W'(OFS_ASEC))  rd_mux = alarm[0];
    else if (reg_addr == ADDR_W'(OFS_AMIN))  rd_mux = alarm[1];
    else if (reg_addr == ADDR_W'(OFS_AHOUR)) rd_mux = alarm[2];
    else if (reg_addr == ADDR_W'(OFS_B))     rd_mux[UF_BIT +: N_SRC] = en;
    else if (reg_addr == ADDR_W'(OFS_C))     rd_mux = pack_flags(irq_sum, flag_bits);
    else if (reg_addr == ADDR_W'(OFS_D))     rd_mux[VRT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R6
  no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_bits == '0) |-> !irq);
  // R6
  no_en_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
  // R2
  alarm_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_bits[1]) |-> $past(upd_done));
  // R9
  vrt_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFS_D)) |=> (reg_rdata == 8'h80));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
`timescale 1ns/1ps
module sim_rtc_alarm_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic       upd_done = 1'b0, per_tick = 1'b0;
  logic       irq;
  int         errors = 0, checks = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  rtc_alarm_irq u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(input logic u, input logic p);
    @(negedge clk); upd_done = u; per_tick = p;
    @(negedge clk); upd_done = 0; per_tick = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h);
    cur_sec = s; cur_min = m; cur_hour = h;
  endtask

  task automatic t_reset;
    rd(6'd1, rv);  chk("R1 reset alarm sec", rv, 8'h00);
    rd(6'd5, rv);  chk("R1 reset alarm hour", rv, 8'h00);
    rd(6'd11, rv); chk("R5 reset enables", rv, 8'h00);
    rd(6'd12, rv); chk("R7 reset flags", rv, 8'h00);
    rd(6'd13, rv); chk("R9 reset status", rv, 8'h80);
    chk("R6 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    wr(6'd1, 8'h10); wr(6'd3, 8'h20); wr(6'd5, 8'h05);
    rd(6'd1, rv); chk("R1 alarm sec", rv, 8'h10);
    rd(6'd3, rv); chk("R1 alarm min", rv, 8'h20);
    rd(6'd5, rv); chk("R1 alarm hour", rv, 8'h05);
    wr(6'd11, 8'hFF);
    rd(6'd11, rv); chk("R5 enable bits only", rv, 8'h70);
    wr(6'd11, 8'h00);
  endtask

  task automatic t_events;
    pulse(0, 1);
    chk("R6 no irq when disabled", {7'd0, irq}, 8'h00);
    rd(6'd12, rv); chk("R4 periodic flag", rv, 8'h40);
    rd(6'd12, rv); chk("R7 cleared by read", rv, 8'h00);
    set_time(8'h59, 8'h20, 8'h05);
    pulse(1, 0);
    rd(6'd12, rv); chk("R4 update flag only", rv, 8'h10);
  endtask

  task automatic t_alarm;
    set_time(8'h10, 8'h20, 8'h05);
    repeat (3) @(negedge clk);
    rd(6'd12, rv); chk("R2 no update no alarm", rv, 8'h00);
    pulse(1, 0);
    rd(6'd12, rv); chk("R2 match on update", rv, 8'h30);
    set_time(8'h11, 8'h20, 8'h05);
    pulse(1, 0);
    rd(6'd12, rv); chk("R2 mismatch sec", rv, 8'h10);
  endtask

  task automatic t_dontcare;
    wr(6'd1, 8'hC0); wr(6'd3, 8'hFF);
    set_time(8'h37, 8'h12, 8'h05);
    pulse(1, 0);
    rd(6'd12, rv); chk("R3 wildcard match", rv, 8'h30);
    set_time(8'h37, 8'h12, 8'h06);
    pulse(1, 0);
    rd(6'd12, rv); chk("R3 exact hour miss", rv, 8'h10);
    wr(6'd1, 8'h80);
    set_time(8'h00, 8'h12, 8'h05);
    pulse(1, 0);
    rd(6'd12, rv); chk("R3 bit7 alone exact", rv, 8'h10);
    wr(6'd1, 8'h10); wr(6'd3, 8'h20);
  endtask

  task automatic t_irq;
    wr(6'd11, 8'h40);
    set_time(8'h00, 8'h00, 8'h00);
    pulse(1, 0);
    chk("R6 disabled update no irq", {7'd0, irq}, 8'h00);
    rd(6'd12, rv); chk("R6 summary clear", rv, 8'h10);
    pulse(0, 1);
    chk("R6 periodic irq", {7'd0, irq}, 8'h01);
    rd(6'd12, rv); chk("R6 summary set", rv, 8'hC0);
    chk("R7 irq drops after read", {7'd0, irq}, 8'h00);
    wr(6'd11, 8'h20);
    set_time(8'h10, 8'h20, 8'h05);
    pulse(1, 0);
    chk("R6 alarm irq", {7'd0, irq}, 8'h01);
    rd(6'd12, rv); chk("R6 alarm summary", rv, 8'hB0);
    wr(6'd11, 8'h10);
    pulse(1, 0);
    chk("R6 update irq", {7'd0, irq}, 8'h01);
    rd(6'd12, rv);
    wr(6'd11, 8'h00);
  endtask

  task automatic t_coincident;
    @(negedge clk); reg_rd = 1; reg_addr = 6'd12; per_tick = 1;
    @(negedge clk); reg_rd = 0; per_tick = 0; rv = reg_rdata;
    chk("R8 event not in clearing read", rv, 8'h00);
    rd(6'd12, rv); chk("R8 event kept", rv, 8'h40);
  endtask

  task automatic t_ignored;
    pulse(0, 1);
    wr(6'd12, 8'h00);
    rd(6'd12, rv); chk("R10 write to flags ignored", rv, 8'h40);
    wr(6'd13, 8'h00);
    rd(6'd13, rv); chk("R9 status not writable", rv, 8'h80);
    wr(6'd14, 8'h55);
    rd(6'd14, rv); chk("R10 unmapped reads zero", rv, 8'h00);
    rd(6'd1, rv);  chk("R10 alarm untouched", rv, 8'h10);
    rd(6'd11, rv); chk("R10 enables untouched", rv, 8'h00);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_events();
    t_alarm();
    t_dontcare();
    t_irq();
    t_coincident();
    t_ignored();
    finish_run();
  end
endmodule